// File: doc/BRIEF.md
# Serial Interface Register Controller

This block is a byte-wide, memory-mapped asynchronous serial controller. A processor reaches it through four registers: a frame-format register, an enable register, a status register and a data register. Behind them, a transmit shifter drives the TX line and a receive deserializer samples the RX line. A frame is a low start bit, 8 or 9 data bits sent least significant bit first, and a high stop bit. Bit timing comes from an external baud generator, which pulses `bit_tick` once per bit time. The transmitter advances on each tick. The receiver samples the line once on each tick.

Software sends a byte by writing the data register while the transmit-empty flag is set. It receives a byte by reading the status register and then the data register. That pair of reads clears the receive-side flags that were set at the moment of the status read, and no others. A single interrupt request combines the status flags with their enables.

Top module: `aser_ctl`

## Requirements
- R1: A transmitted frame lasts 10 bit ticks in 8-bit mode and 11 bit ticks in 9-bit mode. The frame is a low start bit, the data bits LSB first, then (9-bit mode only) format bit 1 as the ninth bit, then a high stop bit. Format register address 0: bit 0 selects 9-bit mode, bit 1 is the ninth transmit bit, and bit 2 is the read-only ninth received bit.
- R2: After reset, the format register (address 0) and the enable register (address 1) read 0x00, the status register (address 2) reads 0xC0, TX is high and irq is low.
- R3: A write to the data register (address 3) is taken only while transmit-empty (status bit 7) is set. A write made while that flag is clear changes nothing and sends nothing.
- R4: When transmit enable (enable bit 3) is set and a byte is pending, transmission starts and clears transmit-empty (status bit 7) and transmit-complete (status bit 6). Both flags are set again when the frame ends.
- R5: A complete received frame stores its byte for reading at address 3 and sets receive-full (status bit 5). In 9-bit mode the ninth received bit appears in format bit 2.
- R6: A frame that completes while receive-full is still set sets overrun (status bit 3). The new byte replaces the old one.
- R7: A status read records which of status bits 5 to 1 are set. A later data read clears exactly the recorded flags. A frame that completes between the two reads discards the record, so the data read then clears nothing.
- R8: The receiver runs only while receive enable (enable bit 2) is set. Clearing that bit abandons a frame in progress, and that frame never sets receive-full.
- R9: A received frame whose stop bit samples low sets framing error (status bit 1).
- R10: irq is high when any of these pairs is set: status bit 7 with enable bit 7; status bit 6 with enable bit 6; status bit 5 or bit 3 with enable bit 5; status bit 4 with enable bit 4.
- R11: After a received frame, once the line has stayed high for a whole frame length of ticks, idle (status bit 4) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 format, 1 enable, 2 status, 3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line, high when idle |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case is the clear sequence that is interrupted: a status read, then a new frame arriving, then a data read. This case must leave receive-full and overrun set. The bench reaches it by reading status after one received frame, driving a second complete frame onto the RX line in step with the tick, and only then reading data. It checks the flags before and after a second full clear sequence. An abandoned reception is reached in a similar way: the bench drives part of a frame, clears receive enable through the bus, and then shows that receive-full stays clear.

// File: rtl/aser_pkg.sv
// Package: shared register addresses and bit positions for the serial
// controller. Assumes a byte-wide register bus.
package aser_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_FMT  = 2'd0,
        A_EN   = 2'd1,
        A_STAT = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    // status bit positions (high to low order is decoded by software)
    localparam int ST_TDRE = 7;
    localparam int ST_TC   = 6;
    localparam int ST_RDRF = 5;
    localparam int ST_IDLE = 4;
    localparam int ST_OVR  = 3;
    localparam int ST_NF   = 2;
    localparam int ST_FE   = 1;

    // enable register bit positions
    localparam int EN_TIE  = 7;
    localparam int EN_TCIE = 6;
    localparam int EN_RIE  = 5;
    localparam int EN_ILIE = 4;
    localparam int EN_TE   = 3;
    localparam int EN_RE   = 2;

    // format register bit positions
    localparam int FM_NINE = 0;
    localparam int FM_T8   = 1;
    localparam int FM_R8   = 2;

    // receive flags recorded by a status read
    localparam logic [7:0] RX_FLAG_MASK = 8'b0011_1110;
    localparam logic [7:0] STAT_RESET   = 8'b1100_0000;
endpackage

// File: rtl/aser_tx.sv
// Transmit shifter: loads start, data, optional ninth bit and stop into a
// shift register and moves one bit per tick. Assumes tick is a one-cycle pulse.
module aser_tx #(
    parameter int DW = aser_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go,
    input  logic          nine,
    input  logic          t8,
    input  logic [DW-1:0] hold,
    output logic          take,
    output logic          done,
    output logic          busy,
    output logic          line
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(FW + 1);
    localparam logic [CW-1:0] LEN9 = CW'(FW);
    localparam logic [CW-1:0] LEN8 = CW'(FW - 1);

    logic [FW-1:0] sh;
    logic [CW-1:0] cnt;

    assign take = go & ~busy;
    assign line = busy ? sh[0] : 1'b1;

    // Purpose: load a frame on take, shift it out one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            sh   <= '1;
        end else begin
            done <= 1'b0;
            if (take) begin
                busy <= 1'b1;
                cnt  <= nine ? LEN9 : LEN8;
                sh   <= nine ? {1'b1, t8, hold, 1'b0} : {2'b11, hold, 1'b0};
            end else if (busy && tick) begin
                sh  <= {1'b1, sh[FW-1:1]};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aser_rx.sv
// Receive deserializer: samples the line once per tick, collects 8 or 9
// data bits after a low start bit, checks the stop bit, and reports an
// idle line after a received frame. Assumes the line is in step with tick.
module aser_rx #(
    parameter int DW = aser_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          nine,
    input  logic          line,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          bit9,
    output logic          stop_bad,
    output logic          idle_hit,
    output logic          busy
);
    localparam int SW = DW + 1;
    localparam int CW = $clog2(DW + 4);
    localparam logic [CW-1:0] NB8 = CW'(DW);
    localparam logic [CW-1:0] NB9 = CW'(DW + 1);

    logic [SW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [CW-1:0] quiet;
    logic          armed;
    logic [CW-1:0] nbits;
    logic [CW-1:0] flen_m1;

    assign nbits   = nine ? NB9 : NB8;
    assign flen_m1 = nbits + CW'(1);

    // Purpose: frame reception, stop check and idle-line counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            idle_hit <= 1'b0;
            armed    <= 1'b0;
            quiet    <= '0;
            cnt      <= '0;
            sh       <= '0;
            data     <= '0;
            bit9     <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done     <= 1'b0;
            idle_hit <= 1'b0;
            if (!en) begin
                busy  <= 1'b0;
                armed <= 1'b0;
                quiet <= '0;
            end else if (tick) begin
                if (!busy) begin
                    if (!line) begin
                        busy  <= 1'b1;
                        cnt   <= '0;
                        quiet <= '0;
                    end else if (armed) begin
                        if (quiet == flen_m1) begin
                            idle_hit <= 1'b1;
                            armed    <= 1'b0;
                            quiet    <= '0;
                        end else begin
                            quiet <= quiet + 1'b1;
                        end
                    end
                end else if (cnt < nbits) begin
                    sh  <= {line, sh[SW-1:1]};
                    cnt <= cnt + 1'b1;
                end else begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    stop_bad <= ~line;
                    armed    <= 1'b1;
                    quiet    <= '0;
                    data     <= nine ? sh[DW-1:0] : sh[SW-1:1];
                    bit9     <= nine ? sh[SW-1] : 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/aser_regs.sv
// Register file and flags: format, enable, status and data registers, the
// pending transmit byte, the two-step clear record and the interrupt.
// Assumes one bus access per cycle with its side effects at that cycle's edge.
module aser_regs
    import aser_pkg::*;
#(
    parameter int DW = aser_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tx_take,
    input  logic              tx_done,
    output logic              tx_go,
    output logic [DW-1:0]     hold,
    output logic              t8,
    output logic              nine,
    output logic              rx_en,
    input  logic              rx_done,
    input  logic [DW-1:0]     rx_data,
    input  logic              rx_bit9,
    input  logic              rx_stop_bad,
    input  logic              rx_idle_hit,
    output logic [7:0]        stat,
    output logic [7:0]        en_reg,
    output logic              irq
);
    logic [7:0]    fmt_q;
    logic [7:0]    mask_q;
    logic [DW-1:0] rx_byte;
    logic          pend_q;
    logic          rd_stat;
    logic          rd_data;
    logic          wr_data;

    assign rd_stat = bus_sel & ~bus_wr & (bus_addr == A_STAT);
    assign rd_data = bus_sel & ~bus_wr & (bus_addr == A_DATA);
    assign wr_data = bus_sel &  bus_wr & (bus_addr == A_DATA);

    assign tx_go = pend_q & en_reg[EN_TE];
    assign t8    = fmt_q[FM_T8];
    assign nine  = fmt_q[FM_NINE];
    assign rx_en = en_reg[EN_RE];

    // Purpose: register writes, transmit flags, clear record and receive flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q   <= '0;
            en_reg  <= '0;
            stat    <= STAT_RESET;
            mask_q  <= '0;
            hold    <= '0;
            pend_q  <= 1'b0;
            rx_byte <= '0;
        end else begin
            if (tx_take) begin
                pend_q        <= 1'b0;
                stat[ST_TDRE] <= 1'b0;
                stat[ST_TC]   <= 1'b0;
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    A_FMT: begin
                        fmt_q[FM_NINE] <= bus_wdata[FM_NINE];
                        fmt_q[FM_T8]   <= bus_wdata[FM_T8];
                    end
                    A_EN: en_reg <= bus_wdata;
                    default: ;
                endcase
            end
            if (wr_data && stat[ST_TDRE]) begin
                hold   <= bus_wdata[DW-1:0];
                pend_q <= 1'b1;
            end
            if (tx_done) begin
                stat[ST_TDRE] <= 1'b1;
                stat[ST_TC]   <= 1'b1;
            end
            if (rd_stat) mask_q <= stat & RX_FLAG_MASK;
            if (rd_data) begin
                for (int i = ST_FE; i <= ST_RDRF; i++) begin
                    if (mask_q[i]) stat[i] <= 1'b0;
                end
                mask_q <= '0;
            end
            if (rx_done) begin
                stat[ST_RDRF] <= 1'b1;
                if (stat[ST_RDRF]) stat[ST_OVR] <= 1'b1;
                if (rx_stop_bad)   stat[ST_FE]  <= 1'b1;
                rx_byte       <= rx_data;
                fmt_q[FM_R8]  <= rx_bit9;
                mask_q        <= '0;
            end
            if (rx_idle_hit) stat[ST_IDLE] <= 1'b1;
        end
    end

    // Purpose: read multiplexer for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_FMT:   bus_rdata = fmt_q;
                A_EN:    bus_rdata = en_reg;
                A_STAT:  bus_rdata = stat;
                default: bus_rdata = rx_byte;
            endcase
        end
    end

    // Purpose: combine flags with their enables into one request.
    always_comb begin
        irq = (stat[ST_TDRE] & en_reg[EN_TIE])
            | (stat[ST_TC]   & en_reg[EN_TCIE])
            | ((stat[ST_RDRF] | stat[ST_OVR]) & en_reg[EN_RIE])
            | (stat[ST_IDLE] & en_reg[EN_ILIE]);
    end
endmodule

// File: rtl/aser_ctl.sv
// Top of the serial interface register controller: connects the register
// file to the transmit shifter and the receive deserializer.
// Assumes bit_tick comes from an external baud generator in this clock domain.
module aser_ctl
    import aser_pkg::*;
#(
    parameter int DW = aser_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ser_rx,
    output logic              ser_tx,
    output logic              irq
);
    logic          tx_take_w, tx_done_w, tx_go_w, tx_busy_w;
    logic [DW-1:0] hold_w;
    logic          t8_w, nine_w, rx_en_w;
    logic          rx_done_w, rx_bit9_w, rx_stop_bad_w, rx_idle_w, rx_busy_w;
    logic [DW-1:0] rx_data_w;
    logic [7:0]    stat_w, en_w;

    aser_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_take(tx_take_w), .tx_done(tx_done_w), .tx_go(tx_go_w),
        .hold(hold_w), .t8(t8_w), .nine(nine_w), .rx_en(rx_en_w),
        .rx_done(rx_done_w), .rx_data(rx_data_w), .rx_bit9(rx_bit9_w),
        .rx_stop_bad(rx_stop_bad_w), .rx_idle_hit(rx_idle_w),
        .stat(stat_w), .en_reg(en_w), .irq(irq)
    );

    aser_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick),
        .go(tx_go_w), .nine(nine_w), .t8(t8_w), .hold(hold_w),
        .take(tx_take_w), .done(tx_done_w), .busy(tx_busy_w), .line(ser_tx)
    );

    aser_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick),
        .en(rx_en_w), .nine(nine_w), .line(ser_rx),
        .done(rx_done_w), .data(rx_data_w), .bit9(rx_bit9_w),
        .stop_bad(rx_stop_bad_w), .idle_hit(rx_idle_w), .busy(rx_busy_w)
    );
endmodule

// File: rtl/aser_ctl_chk.sv
// Checker: temporal properties across the register file and the shifters.
module aser_ctl_chk
    import aser_pkg::*;
#(
    parameter int DW = aser_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        stat,
    input logic [7:0]        en_reg,
    input logic [DW-1:0]     hold,
    input logic              tx_busy,
    input logic              rx_busy,
    input logic              rx_done
);
    AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (stat == STAT_RESET)); // R2
    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DATA && !stat[ST_TDRE]) |=> $stable(hold)); // R3
    AST_TX_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (!stat[ST_TDRE] && !stat[ST_TC])); // R4
    AST_TX_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |=> (stat[ST_TDRE] && stat[ST_TC])); // R4
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && stat[ST_RDRF]) |=> stat[ST_OVR]); // R6
    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_reg[EN_RE] |=> !rx_busy); // R8
endmodule

bind aser_ctl aser_ctl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .stat(stat_w), .en_reg(en_w), .hold(hold_w),
    .tx_busy(tx_busy_w), .rx_busy(rx_busy_w), .rx_done(rx_done_w)
);

// File: tb/aser_ctl_bench.sv
module aser_ctl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ser_rx = 1'b1;
    logic       ser_tx, irq;

    int n_chk = 0, n_fail = 0;
    int tick_n = 0, rd_tick = 0;
    logic [2:0] tdiv = 3'd0;
    logic mon_nine = 1'b0;
    logic [8:0] exp_tx[$];
    logic [8:0] exp_rx[$];

    aser_ctl u_aser_ctl (
        .clk(clk), .rst_n(rst_n), .bit_tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bit tick: one cycle in eight
    always @(posedge clk) begin
        tdiv <= tdiv + 3'd1;
        tick <= (tdiv == 3'd7);
        if (tick) tick_n <= tick_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #(CLK_PERIOD/4);
        v = bus_rdata;
        rd_tick = tick_n;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_wrt(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic tick_slot();
        do @(negedge clk); while (!tick);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) tick_slot();
    endtask

    // driver: puts one frame on the RX line and records the expected byte
    task automatic rx_send(input logic [7:0] d, input logic b9, input logic nine,
                           input logic stop_v, input logic push);
        logic [10:0] bits;
        int n;
        bits = nine ? {stop_v, b9, d, 1'b0} : {1'b1, stop_v, d, 1'b0};
        n = nine ? 11 : 10;
        for (int k = 0; k < n; k++) begin
            tick_slot();
            ser_rx = bits[k];
        end
        tick_slot();
        ser_rx = 1'b1;
        if (push) exp_rx.push_back({b9, d});
    endtask

    task automatic rx_data_chk(input string req);
        logic [7:0] v;
        logic [8:0] e;
        bus_rd(2'd3, v);
        e = exp_rx.pop_front();
        chk(req, v, e[7:0]);
    endtask

    // waits for transmit-empty and returns ticks counted since rd_tick
    task automatic wait_tdre(output int ticks);
        logic [7:0] s;
        int t0;
        bus_rd(2'd2, s);
        chk("R4 start clears empty/complete", s & 8'hC0, 8'h00);
        t0 = rd_tick;
        do bus_rd(2'd2, s); while (!s[7]);
        ticks = rd_tick - t0;
        chk("R4 empty/complete set at frame end", s & 8'hC0, 8'hC0);
    endtask

    // monitor: decodes TX frames and compares them with the scoreboard queue
    initial begin
        logic [10:0] bits;
        logic [10:0] ex, msk;
        logic [8:0]  e;
        int n, k;
        forever begin
            @(negedge clk);
            if (rst_n && ser_tx === 1'b0) begin
                n = mon_nine ? 11 : 10;
                k = 0;
                bits = '0;
                while (k < n) begin
                    if (tick) begin
                        bits[k] = ser_tx;
                        k++;
                    end
                    if (k < n) @(negedge clk);
                end
                if (exp_tx.size() == 0) begin
                    chk("R3 unexpected tx frame", {21'd0, bits}, 32'd0);
                end else begin
                    e = exp_tx.pop_front();
                    msk = mon_nine ? 11'h7FF : 11'h3FF;
                    ex = mon_nine ? {1'b1, e[8], e[7:0], 1'b0} : {2'b01, e[7:0], 1'b0};
                    chk("R1 tx frame bits", {21'd0, bits & msk}, {21'd0, ex & msk});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int t;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        bus_rd(2'd0, v); chk("R2 format reset", v, 8'h00);
        bus_rd(2'd1, v); chk("R2 enable reset", v, 8'h00);
        bus_rd(2'd2, v); chk("R2 status reset", v, 8'hC0);
        chk("R2 irq reset", irq, 0);
        chk("R2 tx idle high", ser_tx, 1);

        // R10 interrupt combinations
        bus_wrt(2'd1, 8'h80); chk("R10 empty with enable", irq, 1);
        bus_wrt(2'd1, 8'h40); chk("R10 complete with enable", irq, 1);
        bus_wrt(2'd1, 8'h20); chk("R10 rx enable without flags", irq, 0);
        bus_wrt(2'd1, 8'h00);

        // R3/R4/R1 8-bit transmit, blocked second write
        bus_wrt(2'd3, 8'h5A);
        bus_rd(2'd2, v); chk("R3 accepted with transmit off", v, 8'hC0);
        exp_tx.push_back({1'b0, 8'h5A});
        bus_wrt(2'd1, 8'h08);
        wait_tdre(t);
        chk("R1 8-bit frame length", t, 10);
        bus_wrt(2'd3, 8'h33);
        exp_tx.push_back({1'b0, 8'h33});
        bus_rd(2'd2, v);
        bus_wrt(2'd3, 8'hFF);
        do bus_rd(2'd2, v); while (!v[7]);
        wait_ticks(14);
        chk("R3 write while busy ignored", ser_tx, 1);
        chk("R3 no extra frame", exp_tx.size(), 0);

        // R1 9-bit transmit
        bus_wrt(2'd0, 8'h03);
        mon_nine = 1'b1;
        exp_tx.push_back({1'b1, 8'hA5});
        bus_wrt(2'd3, 8'hA5);
        wait_tdre(t);
        chk("R1 9-bit frame length", t, 11);
        bus_wrt(2'd0, 8'h01);
        exp_tx.push_back({1'b0, 8'h0F});
        bus_wrt(2'd3, 8'h0F);
        wait_tdre(t);
        wait_ticks(2);
        bus_wrt(2'd0, 8'h00);
        mon_nine = 1'b0;

        // R8 receive disabled
        rx_send(8'h11, 1'b0, 1'b0, 1'b1, 1'b0);
        bus_rd(2'd2, v); chk("R8 no receive while disabled", v, 8'hC0);

        // R5/R7/R11 receive, clear, idle
        bus_wrt(2'd1, 8'h0C);
        rx_send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
        bus_rd(2'd2, v); chk("R5 receive-full set", v & 8'h2A, 8'h20);
        rx_data_chk("R5 received byte");
        bus_rd(2'd2, v); chk("R7 receive-full cleared", v & 8'h20, 8'h00);
        wait_ticks(12);
        bus_rd(2'd2, v); chk("R11 idle set", v & 8'h10, 8'h10);
        bus_wrt(2'd1, 8'h1C); chk("R10 idle with enable", irq, 1);
        bus_rd(2'd2, v); bus_rd(2'd3, v);
        chk("R7 idle cleared irq", irq, 0);
        bus_rd(2'd2, v); chk("R7 idle cleared", v & 8'h10, 8'h00);
        bus_wrt(2'd1, 8'h0C);

        // R6 overrun
        rx_send(8'h01, 1'b0, 1'b0, 1'b1, 1'b1);
        rx_send(8'h02, 1'b0, 1'b0, 1'b1, 1'b1);
        bus_rd(2'd2, v); chk("R6 overrun and full", v & 8'h28, 8'h28);
        bus_wrt(2'd1, 8'h2C); chk("R10 receive flags with enable", irq, 1);
        void'(exp_rx.pop_front());
        bus_rd(2'd2, v);
        rx_data_chk("R6 newest byte kept");
        bus_rd(2'd2, v); chk("R7 overrun and full cleared", v & 8'h28, 8'h00);
        chk("R10 irq drops after clear", irq, 0);
        bus_wrt(2'd1, 8'h0C);

        // R7 record discarded by a frame between the reads
        rx_send(8'h55, 1'b0, 1'b0, 1'b1, 1'b1);
        bus_rd(2'd2, v);
        rx_send(8'h66, 1'b0, 1'b0, 1'b1, 1'b1);
        void'(exp_rx.pop_front());
        rx_data_chk("R7 data after interleaved frame");
        bus_rd(2'd2, v); chk("R7 flags kept after discarded record", v & 8'h28, 8'h28);
        bus_rd(2'd3, v); chk("R7 data reread", v, 8'h66);
        bus_rd(2'd2, v); chk("R7 flags cleared by full sequence", v & 8'h28, 8'h00);

        // R9 framing error
        rx_send(8'h77, 1'b0, 1'b0, 1'b0, 1'b1);
        bus_rd(2'd2, v); chk("R9 framing error set", v & 8'h02, 8'h02);
        rx_data_chk("R9 byte with bad stop");
        bus_rd(2'd2, v); chk("R9 framing error cleared", v & 8'h02, 8'h00);

        // R5 9-bit receive
        bus_wrt(2'd0, 8'h01);
        rx_send(8'h81, 1'b1, 1'b1, 1'b1, 1'b1);
        bus_rd(2'd0, v); chk("R5 ninth bit one", v, 8'h05);
        bus_rd(2'd2, v);
        rx_data_chk("R5 9-bit byte");
        rx_send(8'h42, 1'b0, 1'b1, 1'b1, 1'b1);
        bus_rd(2'd0, v); chk("R5 ninth bit zero", v, 8'h01);
        bus_rd(2'd2, v);
        rx_data_chk("R5 9-bit byte second");
        bus_wrt(2'd0, 8'h00);

        // R8 clearing receive enable abandons a frame
        tick_slot(); ser_rx = 1'b0;
        tick_slot(); ser_rx = 1'b1;
        tick_slot(); ser_rx = 1'b0;
        bus_wrt(2'd1, 8'h08);
        ser_rx = 1'b1;
        wait_ticks(3);
        bus_wrt(2'd1, 8'h0C);
        wait_ticks(12);
        bus_rd(2'd2, v); chk("R8 abandoned frame not stored", v & 8'h20, 8'h00);

        chk("R4 all transmit frames seen", exp_tx.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule